// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block turns one selected input clock into a slower reference clock. The ratio is set by an integer divisor and a trim value in 1/512 steps, and the output period averages 2 × (div + trim/512) input cycles. Each half-period lasts `div` input cycles. A 9-bit phase accumulator gains `trim` at every output edge, and when it wraps, that half-period gets one extra input cycle.

Software reaches the block through two 32-bit registers: a control word at offset 0x00 and a trim word at offset 0x10. Values written to the divisor and the trim land in shadow copies. The running divider takes them over only when software raises the switch-request bit, and only at an output period boundary. Hardware then drops the request bit. The block does not contain the input multiplexer. It drives a 4-bit source code out and is clocked by whichever input that code picked.

Top module: `frac_refclk_div`

## Requirements
- R1: After synchronous reset both registers read 0, and `ref_clk_o`, `ref_pin_o`, `ref_pin_oe_o` and `src_sel_o` are 0.
- R2: Control word layout: source code in bits 3:0, status flag in bit 8, switch request in bit 9, pin enable in bit 12, run enable in bit 15, divisor in bits 30:16. All other bits read 0. The trim word holds the trim in bits 31:23 and reads 0 elsewhere. Writes to any other offset change nothing. The status flag ignores writes.
- R3: With trim 0 and divisor D ≥ 1, the output is high for D input cycles and low for D input cycles.
- R4: With trim T, each half-period lasts D or D+1 cycles. Starting from an accumulator of 0, the block adds T to a 9-bit sum at every half-period, and a half gets D+1 exactly when that sum carries past 511. The first half after a start is a high phase.
- R5: Divisor or trim writes without a switch request leave the running ratio unchanged. After a request, the new values take over at the next low-to-high boundary, or at once when the divider is stopped.
- R6: The switch-request bit is set only by writing 1 to it. It reads 1 in the cycle of the transfer and 0 from the cycle after.
- R7: A divisor of 0 yields no output toggling, and the status flag stays 0.
- R8: Clearing the run enable during a high phase lets that phase finish its full length. The output then stays low. Clearing it during a low phase stops the divider at once.
- R9: The status flag (bit 8) reads 1 while the divider runs and 0 once it has stopped.
- R10: `src_sel_o` follows control bits 3:0. `ref_pin_o` is the divided clock ANDed with the pin enable. `ref_pin_oe_o` equals the pin enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_sel_o | output | 4 | Source code driven to the external input multiplexer |
| ref_clk_o | output | 1 | Divided reference clock |
| ref_pin_o | output | 1 | Divided clock gated by the pin enable |
| ref_pin_oe_o | output | 1 | Pin output enable |

## Verification
Two events can land on the same input cycle: the period boundary where the running divider absorbs a pending switch, and the rising output edge that begins the next period. To provoke this, the bench writes a switch request in the middle of a low phase. It then watches the first rising edge, where the request bit must still read 1, and the cycle after it, where the bit must read 0. A scoreboard then measures every following half-period against lengths computed from the new ratio. A second pairing covers a disable that arrives while the output is high: the high phase that is under way must still last its full length before the output parks low.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

    localparam int DIV_W   = 15;
    localparam int TRIM_W  = 9;
    localparam int SRC_W   = 4;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = DIV_W + 1;

    // control word bit positions
    localparam int SRC_LSB   = 0;
    localparam int ACT_BIT   = 8;
    localparam int SW_BIT    = 9;
    localparam int OE_BIT    = 12;
    localparam int ON_BIT    = 15;
    localparam int DIV_LSB   = 16;
    // trim word bit position
    localparam int TRIM_LSB  = 23;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic              on;
        logic              oe;
        logic [DIV_W-1:0]  div;
        logic [TRIM_W-1:0] trim;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0]  len;
        logic [TRIM_W-1:0] acc;
    } half_t;

    // length of the next half-period and the updated phase accumulator
    function automatic half_t next_half(logic [DIV_W-1:0] d,
                                        logic [TRIM_W-1:0] t,
                                        logic [TRIM_W-1:0] a);
        logic [TRIM_W:0] s;
        half_t h;
        s     = {1'b0, a} + {1'b0, t};
        h.acc = s[TRIM_W-1:0];
        h.len = {1'b0, d} + {{DIV_W{1'b0}}, s[TRIM_W]};
        return h;
    endfunction

endpackage

// File: rtl/fracdiv_regs.sv
module fracdiv_regs
    import fracdiv_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CTL_OFS   = 'h00,
    parameter int TRIM_OFS  = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              active_i,
    input  logic              xfer_i,
    output cfg_t              cfg_o,
    output logic              sw_live_o
);

    cfg_t cfg_q;
    logic sw_q;
    logic clr_q;

    logic wr_ctl, wr_trim;
    assign wr_ctl  = wr_en && (addr == ADDR_W'(CTL_OFS));
    assign wr_trim = wr_en && (addr == ADDR_W'(TRIM_OFS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sw_q  <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= xfer_i;
            if (wr_ctl) begin
                cfg_q.src <= wdata[SRC_LSB +: SRC_W];
                cfg_q.oe  <= wdata[OE_BIT];
                cfg_q.on  <= wdata[ON_BIT];
                cfg_q.div <= wdata[DIV_LSB +: DIV_W];
            end
            if (wr_trim)
                cfg_q.trim <= wdata[TRIM_LSB +: TRIM_W];
            if (wr_ctl && wdata[SW_BIT])
                sw_q <= 1'b1;
            else if (clr_q)
                sw_q <= 1'b0;
        end
    end

    assign cfg_o     = cfg_q;
    assign sw_live_o = sw_q & ~clr_q;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTL_OFS)) begin
            rdata[SRC_LSB +: SRC_W] = cfg_q.src;
            rdata[ACT_BIT]          = active_i;
            rdata[SW_BIT]           = sw_q;
            rdata[OE_BIT]           = cfg_q.oe;
            rdata[ON_BIT]           = cfg_q.on;
            rdata[DIV_LSB +: DIV_W] = cfg_q.div;
        end else if (addr == ADDR_W'(TRIM_OFS)) begin
            rdata[TRIM_LSB +: TRIM_W] = cfg_q.trim;
        end
    end

    // R6: a request is dropped the cycle after a transfer unless rewritten
    assert_sw_selfclear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_q && !(wr_ctl && wdata[SW_BIT])) |=> !sw_q);

    // R6: writing 1 always raises the request
    assert_sw_set_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && wdata[SW_BIT]) |=> sw_q);

    // R10: source code moves only on a control write
    assert_src_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_ctl |=> $stable(cfg_q.src));

endmodule

// File: rtl/fracdiv_engine.sv
module fracdiv_engine
    import fracdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              on_i,
    input  logic [DIV_W-1:0]  div_sh,
    input  logic [TRIM_W-1:0] trim_sh,
    input  logic              sw_i,
    output logic              out_o,
    output logic              active_o,
    output logic              xfer_o
);

    logic              out_q, act_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TRIM_W-1:0] acc_q;
    logic [DIV_W-1:0]  run_div;
    logic [TRIM_W-1:0] run_trim;

    half_t h_run, h_new, h_start;
    logic  last, boundary, xfer;

    always_comb begin
        h_run    = next_half(run_div, run_trim, acc_q);
        h_new    = next_half(div_sh, trim_sh, acc_q);
        h_start  = next_half(run_div, run_trim, '0);
        last     = act_q && (cnt_q == CNT_W'(1));
        boundary = !act_q || (last && !out_q);
        xfer     = sw_i && boundary;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q    <= 1'b0;
            act_q    <= 1'b0;
            cnt_q    <= '0;
            acc_q    <= '0;
            run_div  <= '0;
            run_trim <= '0;
        end else begin
            if (xfer) begin
                run_div  <= div_sh;
                run_trim <= trim_sh;
            end
            if (!act_q) begin
                if (!sw_i && on_i && (run_div != '0)) begin
                    act_q <= 1'b1;
                    out_q <= 1'b1;
                    cnt_q <= h_start.len;
                    acc_q <= h_start.acc;
                end else begin
                    acc_q <= '0;
                end
            end else if (!on_i && !out_q) begin
                act_q <= 1'b0;
                acc_q <= '0;
            end else if (!last) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (out_q) begin
                out_q <= 1'b0;
                if (!on_i) begin
                    act_q <= 1'b0;
                    acc_q <= '0;
                end else begin
                    cnt_q <= h_run.len;
                    acc_q <= h_run.acc;
                end
            end else if (xfer) begin
                if (div_sh == '0) begin
                    act_q <= 1'b0;
                    acc_q <= '0;
                end else begin
                    out_q <= 1'b1;
                    cnt_q <= h_new.len;
                    acc_q <= h_new.acc;
                end
            end else begin
                out_q <= 1'b1;
                cnt_q <= h_run.len;
                acc_q <= h_run.acc;
            end
        end
    end

    assign out_o    = out_q;
    assign active_o = act_q;
    assign xfer_o   = xfer;

    // R8: a stopped divider always parks low
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !act_q |-> !out_q);

    // R7: the divider never runs with a zero divisor
    assert_no_zero_run_R7: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (run_div != '0));

    // R5: running ratio is frozen away from period boundaries
    assert_ratio_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (act_q && !(cnt_q == CNT_W'(1) && !out_q)) |=> ($stable(run_div) && $stable(run_trim)));

    // R8: disable inside a high phase keeps it high until its last cycle
    assert_finish_high_R8: assert property (@(posedge clk) disable iff (rst)
        (act_q && out_q && !on_i && cnt_q != CNT_W'(1)) |=> out_q);

    // R8: the last high cycle under disable ends low and idle
    assert_park_R8: assert property (@(posedge clk) disable iff (rst)
        (act_q && out_q && !on_i && cnt_q == CNT_W'(1)) |=> (!out_q && !act_q));

    // R4: a half-period is never longer than div + 1
    assert_half_bound_R4: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (cnt_q <= ({1'b0, run_div} + CNT_W'(1))));

endmodule

// File: rtl/frac_refclk_div.sv
module frac_refclk_div
    import fracdiv_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CTL_OFS  = 'h00,
    parameter int TRIM_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SRC_W-1:0]  src_sel_o,
    output logic              ref_clk_o,
    output logic              ref_pin_o,
    output logic              ref_pin_oe_o
);

    cfg_t cfg;
    logic sw_live, active, xfer, div_out;

    fracdiv_regs #(
        .ADDR_W   (ADDR_W),
        .CTL_OFS  (CTL_OFS),
        .TRIM_OFS (TRIM_OFS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .active_i  (active),
        .xfer_i    (xfer),
        .cfg_o     (cfg),
        .sw_live_o (sw_live)
    );

    fracdiv_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .on_i     (cfg.on),
        .div_sh   (cfg.div),
        .trim_sh  (cfg.trim),
        .sw_i     (sw_live),
        .out_o    (div_out),
        .active_o (active),
        .xfer_o   (xfer)
    );

    assign src_sel_o    = cfg.src;
    assign ref_clk_o    = div_out;
    assign ref_pin_o    = div_out & cfg.oe;
    assign ref_pin_oe_o = cfg.oe;

endmodule

// File: tb/frac_refclk_div_bench.sv
`timescale 1ns/1ps
module frac_refclk_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  src_sel;
    logic        ref_clk, ref_pin, ref_pin_oe;

    always #2.5 clk = ~clk;

    frac_refclk_div u_frac_refclk_div (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .src_sel_o    (src_sel),
        .ref_clk_o    (ref_clk),
        .ref_pin_o    (ref_pin),
        .ref_pin_oe_o (ref_pin_oe)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    exp_q[$];
    string mon_req = "R3";
    bit    mon_en = 1'b0;
    logic [3:0] cur_src = 4'd0;
    logic       cur_oe  = 1'b0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(logic [3:0] s, logic oe, logic on, logic sw, logic [14:0] d);
        return {1'b0, d, on, 2'b00, oe, 2'b00, sw, 1'b0, 4'b0000, s};
    endfunction

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #0.5; d = reg_rdata; reg_addr = 8'h00;
    endtask

    // scoreboard monitor: measures each half-period after the first rise
    initial begin : monitor
        logic prev;
        int   run;
        bit   ok;
        prev = 1'b0; run = 0; ok = 1'b0;
        forever begin
            @(negedge clk);
            if (!mon_en) begin
                ok = 1'b0; prev = ref_clk; run = 0;
            end else if (ref_clk != prev) begin
                if (ok && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    chk(run == e, mon_req, run, e);
                end
                if (ref_clk) ok = 1'b1;
                prev = ref_clk; run = 1;
            end else begin
                run++;
            end
        end
    end

    task automatic push_halves(int d, int t, int n);
        int acc;
        acc = 0;
        for (int i = 0; i < n; i++) begin
            int s;
            s = acc + t;
            exp_q.push_back(d + (s >= 512 ? 1 : 0));
            acc = s % 512;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(8'h00, v);
            if (!v[8]) break;
            @(negedge clk);
        end
    endtask

    // stop, reprogram, switch and start; scoreboard n half-periods
    task automatic run_cfg(int d, int t, int n, string req);
        logic [31:0] v;
        wr(8'h00, ctl(cur_src, cur_oe, 1'b0, 1'b0, 15'(d)));
        wait_idle();
        wr(8'h10, 32'(t) << 23);
        mon_req = req;
        push_halves(d, t, n);
        mon_en = 1'b1;
        wr(8'h00, ctl(cur_src, cur_oe, 1'b1, 1'b1, 15'(d)));
        while (exp_q.size() != 0) @(negedge clk);
        mon_en = 1'b0;
        rd(8'h00, v);
        chk(v[8] == 1'b1, "R9", v[8], 1);
        chk(v[9] == 1'b0, "R6", v[9], 0);
    endtask

    task automatic wait_edge(logic lvl);
        logic p;
        p = ref_clk;
        forever begin
            @(negedge clk);
            if (ref_clk == lvl && p != lvl) break;
            p = ref_clk;
        end
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : driver
        logic [31:0] v;
        int hi, bad, tog;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk(v == 32'h0, "R1", v, 0);
        rd(8'h10, v); chk(v == 32'h0, "R1", v, 0);
        chk({ref_clk, ref_pin, ref_pin_oe, src_sel} == 7'h0, "R1",
            {ref_clk, ref_pin, ref_pin_oe, src_sel}, 0);

        // R2 register layout; status bit 8 ignores writes
        wr(8'h00, ctl(4'd8, 1'b1, 1'b0, 1'b0, 15'h1234) | 32'h8000_6CF0 | 32'h100);
        rd(8'h00, v); chk(v == ctl(4'd8, 1'b1, 1'b0, 1'b0, 15'h1234), "R2", v, ctl(4'd8, 1'b1, 1'b0, 1'b0, 15'h1234));
        wr(8'h10, (32'h1A5 << 23) | 32'h007F_FFFF);
        rd(8'h10, v); chk(v == (32'h1A5 << 23), "R2", v, 32'h1A5 << 23);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h00, v); chk(v == ctl(4'd8, 1'b1, 1'b0, 1'b0, 15'h1234), "R2", v, ctl(4'd8, 1'b1, 1'b0, 1'b0, 15'h1234));
        chk(src_sel == 4'd8, "R10", src_sel, 8);
        chk(ref_pin_oe == 1'b1, "R10", ref_pin_oe, 1);

        // R3 integer ratios, R4 fractional ratios
        cur_src = 4'd7; cur_oe = 1'b1;
        run_cfg(1, 0, 8, "R3");
        run_cfg(3, 0, 8, "R3");
        run_cfg(2, 256, 12, "R4");
        run_cfg(3, 511, 20, "R4");
        run_cfg(5, 100, 24, "R4");
        run_cfg(1, 1, 16, "R4");

        // R10 pin follows divided clock when enabled
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ref_pin != ref_clk) bad++;
        end
        chk(bad == 0, "R10", bad, 0);

        // R8 disable during a high phase
        run_cfg(4, 0, 4, "R3");
        wait_edge(1'b1);
        hi = 1;
        reg_addr = 8'h00; reg_wdata = ctl(cur_src, cur_oe, 1'b0, 1'b0, 15'd4); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        while (ref_clk) begin hi++; @(negedge clk); end
        chk(hi == 4, "R8", hi, 4);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ref_clk) bad++;
        end
        chk(bad == 0, "R8", bad, 0);
        rd(8'h00, v); chk(v[8] == 1'b0, "R9", v[8], 0);

        // R5 write without switch leaves running ratio alone
        run_cfg(3, 0, 4, "R3");
        wr(8'h00, ctl(cur_src, cur_oe, 1'b1, 1'b0, 15'd5));
        mon_req = "R5"; push_halves(3, 0, 6); mon_en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        mon_en = 1'b0;

        // R6 request timing at the transfer, R5 new ratio afterwards
        wait_edge(1'b0);
        wr(8'h00, ctl(cur_src, cur_oe, 1'b1, 1'b1, 15'd5));
        wait_edge(1'b1);
        rd(8'h00, v); chk(v[9] == 1'b1, "R6", v[9], 1);
        @(negedge clk);
        rd(8'h00, v); chk(v[9] == 1'b0, "R6", v[9], 0);
        mon_req = "R5"; push_halves(5, 0, 6); mon_en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        mon_en = 1'b0;

        // R7 zero divisor stops output
        wr(8'h00, ctl(cur_src, cur_oe, 1'b1, 1'b1, 15'd0));
        repeat (30) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ref_clk) bad++;
        end
        chk(bad == 0, "R7", bad, 0);
        rd(8'h00, v); chk(v[8] == 1'b0, "R7", v[8], 0);
        chk(v[9] == 1'b0, "R7", v[9], 0);

        // R10 pin gated off, source code follows field
        cur_src = 4'd0; cur_oe = 1'b0;
        run_cfg(2, 0, 4, "R3");
        chk(src_sel == 4'd0, "R10", src_sel, 0);
        bad = 0; tog = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ref_pin) bad++;
            if (ref_clk) tog++;
        end
        chk(bad == 0 && tog > 0 && !ref_pin_oe, "R10", bad, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule